// File: doc/BRIEF.md
# Fetch Redirect Controller with Sign-Based Static Prediction

This block steers instruction fetch for a five-stage, single-issue pipeline with 32-bit instructions. It owns the fetch program counter and the register that carries one fetched word into the decode stage. While a word is still in the fetch stage, the block pre-decodes it. If the word is a conditional branch with a negative displacement, fetch jumps straight to the branch target. Any other word lets fetch fall through to the next sequential word. Since the prediction is made in fetch, a correct guess in either direction costs no cycle.

The decode stage holds the branch and compares its registers. It returns the outcome to the block on `id_cmp_taken`. The block recomputes the target from the stored PC and offset and compares the real outcome with the prediction it recorded. On a mismatch, it raises `flush_ifid` in the same cycle and loads the correct-path address into the PC. It also replaces the wrongly fetched word with an all-zero, invalid bubble. A misprediction therefore costs exactly one slot. Two wrapping counters track how many branches were resolved and how many of them were mispredicted.

Top module: `bp_fetch_ctrl`

## Requirements
- R1: A synchronous reset, sampled at a rising edge, leaves `fetch_pc` at 0, `ifid_valid` at 0 and both counters at 0 after that edge.
- R2: A word is a conditional branch when bits [31:26] equal 6'b000100. Its displacement is bits [15:0], read as a two's-complement count of words. Its target is (branch PC + 4) + (sign-extended displacement × 4).
- R3: When the word in fetch is a branch with bit 15 set (backward), `next_pc` is that branch's target and no bubble is inserted.
- R4: When the word in fetch is not a branch, or is a branch with bit 15 clear (forward or zero displacement), `next_pc` is `fetch_pc` + 4.
- R5: `flush_ifid` is high in a cycle exactly when `ifid_valid` is high, the decode word is a branch, and `id_cmp_taken` differs from `ifid_pred_taken`.
- R6: When `flush_ifid` is high, `next_pc` is the decode branch's target if `id_cmp_taken` is 1, and otherwise the decode branch's PC + 4. The word currently in fetch is discarded.
- R7: The edge after a flush loads a bubble: `ifid_valid`, `ifid_instr`, `ifid_pc` and `ifid_pred_taken` all become 0.
- R8: Without a flush, every edge loads the fetched word, its PC and its prediction into the decode register with `ifid_valid` = 1, so a correct prediction loses no slot.
- R9: `branch_cnt` increases by one at each edge where a valid branch sits in decode. `mispredict_cnt` increases by one at each edge where `flush_ifid` is high. Both wrap modulo 2^CNT_W.
- R10: `id_cmp_taken` has no effect on any output while decode holds no valid branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| if_instr | input | 32 | Word fetched from `fetch_pc` |
| id_cmp_taken | input | 1 | Register comparison outcome of the branch in decode (1 = taken) |
| fetch_pc | output | 32 | Current fetch address |
| next_pc | output | 32 | Fetch address for the next cycle |
| ifid_valid | output | 1 | Decode register holds a live word |
| ifid_instr | output | 32 | Word held in the decode register |
| ifid_pc | output | 32 | Address of the word in decode |
| ifid_pred_taken | output | 1 | Direction predicted for the word in decode |
| flush_ifid | output | 1 | Misprediction strobe: squash the word now in fetch |
| branch_cnt | output | CNT_W | Count of branches resolved in decode |
| mispredict_cnt | output | CNT_W | Count of mispredictions |

## Verification
The assertions assume two things about the inputs. First, `if_instr` is a pure function of `fetch_pc` within a cycle. Second, `id_cmp_taken` is settled before the rising edge and is meaningful only while decode holds a valid branch. The bench meets both conditions. It derives every fetched word from a computed program image indexed by `fetch_pc`, mixing backward, forward and zero-offset branches. It drives `id_cmp_taken` only at falling edges. Across separate phases it sets the outcome equal to the prediction, opposite to it, or pseudo-random, and it toggles the outcome freely even when no branch is in decode.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int PC_W    = 32;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int OFF_W   = 16;
    localparam int STEP    = INSTR_W / 8;
    localparam logic [OPC_W-1:0] BR_OPCODE = 6'b000100;

    typedef struct packed {
        logic               valid;
        logic [INSTR_W-1:0] instr;
        logic [PC_W-1:0]    pc;
        logic               pred;
    } dec_reg_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        dec_reg_t        dec;
    } fetch_state_t;

    localparam dec_reg_t DEC_BUBBLE = '{valid: 1'b0, instr: '0, pc: '0, pred: 1'b0};
endpackage

// File: rtl/bp_predecode.sv
module bp_predecode
    import bp_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPCODE = BR_OPCODE
) (
    input  logic [INSTR_W-1:0] word,
    output logic               is_branch,
    output logic               backward,
    output logic [PC_W-1:0]    disp_bytes
);
    localparam int SHIFT = $clog2(STEP);
    localparam int EXT_W = PC_W - OFF_W - SHIFT;

    logic [OFF_W-1:0] off;

    always_comb begin
        off        = word[OFF_W-1:0];
        is_branch  = (word[INSTR_W-1 -: OPC_W] == OPCODE);
        backward   = off[OFF_W-1];
        disp_bytes = {{EXT_W{off[OFF_W-1]}}, off, {SHIFT{1'b0}}};
    end
endmodule

// File: rtl/bp_target.sv
module bp_target
    import bp_pkg::*;
(
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] disp_bytes,
    output logic [PC_W-1:0] seq_pc,
    output logic [PC_W-1:0] tgt_pc
);
    always_comb begin
        seq_pc = pc + PC_W'(STEP);
        tgt_pc = seq_pc + disp_bytes;
    end
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve
    import bp_pkg::*;
(
    input  logic            valid,
    input  logic            is_branch,
    input  logic            pred,
    input  logic            actual,
    input  logic [PC_W-1:0] seq_pc,
    input  logic [PC_W-1:0] tgt_pc,
    output logic            resolved,
    output logic            mispredict,
    output logic [PC_W-1:0] fix_pc
);
    always_comb begin
        resolved   = valid && is_branch;
        mispredict = resolved && (actual != pred);
        fix_pc     = actual ? tgt_pc : seq_pc;
    end
endmodule

// File: rtl/bp_counters.sv
module bp_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_branch,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] branch_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] br;
        logic [CNT_W-1:0] miss;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_branch) cnt_d.br   = cnt_q.br + CNT_W'(1);
        if (inc_miss)   cnt_d.miss = cnt_q.miss + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign branch_cnt = cnt_q.br;
    assign miss_cnt   = cnt_q.miss;
endmodule

// File: rtl/bp_fetch_ctrl.sv
module bp_fetch_ctrl
    import bp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] if_instr,
    input  logic               id_cmp_taken,
    output logic [PC_W-1:0]    fetch_pc,
    output logic [PC_W-1:0]    next_pc,
    output logic               ifid_valid,
    output logic [INSTR_W-1:0] ifid_instr,
    output logic [PC_W-1:0]    ifid_pc,
    output logic               ifid_pred_taken,
    output logic               flush_ifid,
    output logic [CNT_W-1:0]   branch_cnt,
    output logic [CNT_W-1:0]   mispredict_cnt
);
    localparam int NSTAGE = 2;
    localparam int S_IF   = 0;
    localparam int S_ID   = 1;

    fetch_state_t st_d, st_q;

    logic [INSTR_W-1:0] word     [NSTAGE];
    logic [PC_W-1:0]    base_pc  [NSTAGE];
    logic               is_br    [NSTAGE];
    logic               bwd      [NSTAGE];
    logic [PC_W-1:0]    disp     [NSTAGE];
    logic [PC_W-1:0]    seq      [NSTAGE];
    logic [PC_W-1:0]    tgt      [NSTAGE];

    logic            resolved;
    logic            mispredict;
    logic [PC_W-1:0] fix_pc;

    assign word[S_IF]    = if_instr;
    assign base_pc[S_IF] = st_q.pc;
    assign word[S_ID]    = st_q.dec.instr;
    assign base_pc[S_ID] = st_q.dec.pc;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        bp_predecode #(.OPCODE(BR_OPCODE)) u_pre (
            .word       (word[g]),
            .is_branch  (is_br[g]),
            .backward   (bwd[g]),
            .disp_bytes (disp[g])
        );
        bp_target u_tgt (
            .pc         (base_pc[g]),
            .disp_bytes (disp[g]),
            .seq_pc     (seq[g]),
            .tgt_pc     (tgt[g])
        );
    end

    bp_resolve u_res (
        .valid      (st_q.dec.valid),
        .is_branch  (is_br[S_ID]),
        .pred       (st_q.dec.pred),
        .actual     (id_cmp_taken),
        .seq_pc     (seq[S_ID]),
        .tgt_pc     (tgt[S_ID]),
        .resolved   (resolved),
        .mispredict (mispredict),
        .fix_pc     (fix_pc)
    );

    bp_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .inc_branch (resolved),
        .inc_miss   (mispredict),
        .branch_cnt (branch_cnt),
        .miss_cnt   (mispredict_cnt)
    );

    always_comb begin
        logic if_pred;
        if_pred = is_br[S_IF] && bwd[S_IF];
        st_d    = st_q;
        if (mispredict) begin
            st_d.pc  = fix_pc;
            st_d.dec = DEC_BUBBLE;
        end else begin
            st_d.pc        = if_pred ? tgt[S_IF] : seq[S_IF];
            st_d.dec.valid = 1'b1;
            st_d.dec.instr = if_instr;
            st_d.dec.pc    = st_q.pc;
            st_d.dec.pred  = if_pred;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{pc: '0, dec: DEC_BUBBLE};
        else     st_q <= st_d;
    end

    assign fetch_pc        = st_q.pc;
    assign next_pc         = st_d.pc;
    assign ifid_valid      = st_q.dec.valid;
    assign ifid_instr      = st_q.dec.instr;
    assign ifid_pc         = st_q.dec.pc;
    assign ifid_pred_taken = st_q.dec.pred;
    assign flush_ifid      = mispredict;
endmodule

// File: rtl/bp_fetch_ctrl_chk.sv
module bp_fetch_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [31:0]      if_instr,
    input logic             id_cmp_taken,
    input logic [31:0]      fetch_pc,
    input logic [31:0]      next_pc,
    input logic             ifid_valid,
    input logic [31:0]      ifid_instr,
    input logic [31:0]      ifid_pc,
    input logic             ifid_pred_taken,
    input logic             flush_ifid,
    input logic [CNT_W-1:0] branch_cnt,
    input logic [CNT_W-1:0] mispredict_cnt
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (fetch_pc == 32'd0 && !ifid_valid && branch_cnt == '0 && mispredict_cnt == '0));

    assert_fwd_fallthrough_R4: assert property (@(posedge clk) disable iff (rst)
        (!flush_ifid && if_instr[31:26] == 6'b000100 && !if_instr[15]) |-> next_pc == fetch_pc + 32'd4);

    assert_flush_needs_branch_R5: assert property (@(posedge clk) disable iff (rst)
        flush_ifid |-> (ifid_valid && ifid_instr[31:26] == 6'b000100));

    assert_redirect_seq_R6: assert property (@(posedge clk) disable iff (rst)
        (flush_ifid && !id_cmp_taken) |=> fetch_pc == $past(ifid_pc) + 32'd4);

    assert_squash_bubble_R7: assert property (@(posedge clk) disable iff (rst)
        flush_ifid |=> (!ifid_valid && ifid_instr == 32'd0 && !ifid_pred_taken));

    assert_no_lost_slot_R8: assert property (@(posedge clk) disable iff (rst)
        !flush_ifid |=> ifid_valid);

    assert_miss_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !flush_ifid |=> $stable(mispredict_cnt));
endmodule

bind bp_fetch_ctrl bp_fetch_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .if_instr        (if_instr),
    .id_cmp_taken    (id_cmp_taken),
    .fetch_pc        (fetch_pc),
    .next_pc         (next_pc),
    .ifid_valid      (ifid_valid),
    .ifid_instr      (ifid_instr),
    .ifid_pc         (ifid_pc),
    .ifid_pred_taken (ifid_pred_taken),
    .flush_ifid      (flush_ifid),
    .branch_cnt      (branch_cnt),
    .mispredict_cnt  (mispredict_cnt)
);

// File: tb/bp_fetch_ctrl_tb_top.sv
module bp_fetch_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 16;
    localparam int MAX_CYC    = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   if_instr;
    logic          id_cmp_taken = 1'b0;
    logic [31:0]   fetch_pc, next_pc, ifid_instr, ifid_pc;
    logic          ifid_valid, ifid_pred_taken, flush_ifid;
    logic [CW-1:0] branch_cnt, mispredict_cnt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // model state
    logic [31:0] m_pc = 0, m_instr = 0, m_idpc = 0;
    bit          m_v = 0, m_pred = 0;
    int          m_bc = 0, m_mc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_fetch_ctrl #(.CNT_W(CW)) dut_i (
        .clk (clk), .rst (rst), .if_instr (if_instr), .id_cmp_taken (id_cmp_taken),
        .fetch_pc (fetch_pc), .next_pc (next_pc), .ifid_valid (ifid_valid),
        .ifid_instr (ifid_instr), .ifid_pc (ifid_pc), .ifid_pred_taken (ifid_pred_taken),
        .flush_ifid (flush_ifid), .branch_cnt (branch_cnt), .mispredict_cnt (mispredict_cnt)
    );

    // program image: branch opcode 6'b000100 in [31:26], word offset in [15:0] (R2)
    function automatic logic [31:0] prog(input logic [31:0] a);
        int i;
        i = int'(a[9:2]);
        if (i % 5 == 2 && i >= 8) return {6'b000100, 10'd0, 16'hFFFD};
        if (i % 7 == 3)           return {6'b000100, 10'd0, 16'd2};
        if (i % 11 == 6)          return {6'b000100, 10'd0, 16'd0};
        if (i % 13 == 9)          return {6'b000100, 10'd0, 16'hFFF0};
        return {6'b001000, 10'd0, 16'(i)};
    endfunction

    function automatic bit is_br(input logic [31:0] w);
        return w[31:26] == 6'b000100;
    endfunction

    function automatic logic [31:0] tgt_of(input logic [31:0] pc, input logic [31:0] w);
        int off;
        off = int'($signed(w[15:0]));
        return pc + 32'd4 + 32'(off * 4);
    endfunction

    assign if_instr = prog(fetch_pc);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, compare, step model at posedge
    task automatic cycle(input int mode, input bit do_rst, inout logic [15:0] lfsr);
        bit          f, fpred, cmp;
        logic [31:0] fw, npc, fix;
        @(negedge clk);
        rst = do_rst;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (mode)
            0:       cmp = m_pred;
            1:       cmp = !m_pred;
            default: cmp = lfsr[0];
        endcase
        id_cmp_taken = cmp;
        #1;
        fw    = prog(m_pc);
        fpred = is_br(fw) && fw[15];
        f     = m_v && is_br(m_instr) && (cmp != m_pred);
        fix   = cmp ? tgt_of(m_idpc, m_instr) : m_idpc + 32'd4;
        npc   = f ? fix : (fpred ? tgt_of(m_pc, fw) : m_pc + 32'd4);
        chk("R1/R8 fetch_pc", fetch_pc, m_pc);
        chk("R7/R8 ifid_valid", 32'(ifid_valid), 32'(m_v));
        chk("R7/R8 ifid_instr", ifid_instr, m_instr);
        chk("R7 ifid_pc", ifid_pc, m_idpc);
        chk("R7 ifid_pred_taken", 32'(ifid_pred_taken), 32'(m_pred));
        if (!(m_v && is_br(m_instr)))
            chk("R10 flush without branch", 32'(flush_ifid), 32'd0);
        else
            chk("R5 flush", 32'(flush_ifid), 32'(f));
        if (f)               chk("R6 redirect", next_pc, npc);
        else if (fpred)      chk("R3 backward taken", next_pc, npc);
        else                 chk("R4 fall through", next_pc, npc);
        chk("R9 branch_cnt", 32'(branch_cnt), 32'(CW'(m_bc)));
        chk("R9 mispredict_cnt", 32'(mispredict_cnt), 32'(CW'(m_mc)));
        @(posedge clk);
        if (do_rst) begin
            m_pc = 0; m_v = 0; m_instr = 0; m_idpc = 0; m_pred = 0; m_bc = 0; m_mc = 0;
        end else begin
            if (m_v && is_br(m_instr)) m_bc++;
            if (f) begin
                m_mc++;
                m_v = 0; m_instr = 0; m_idpc = 0; m_pred = 0;
            end else begin
                m_v = 1; m_instr = fw; m_idpc = m_pc; m_pred = fpred;
            end
            m_pc = npc;
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        cycle(2, 1'b1, lfsr);
        cycle(2, 1'b1, lfsr);
        // R1: reset state at the ports
        @(negedge clk);
        chk("R1 reset pc", fetch_pc, 32'd0);
        chk("R1 reset valid", 32'(ifid_valid), 32'd0);
        chk("R1 reset branch_cnt", 32'(branch_cnt), 32'd0);
        chk("R1 reset mispredict_cnt", 32'(mispredict_cnt), 32'd0);
        for (int k = 0; k < 400; k++) cycle(0, 1'b0, lfsr);   // R8: all predictions right
        chk("R8 no mispredictions when outcome matches", 32'(mispredict_cnt), 32'd0);
        for (int k = 0; k < 400; k++) cycle(1, 1'b0, lfsr);   // R6/R7: all wrong
        cycle(2, 1'b1, lfsr);
        for (int k = 0; k < 3000; k++) cycle(2, (k == 1500), lfsr);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * MAX_CYC);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule